// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible register file of a color LCD controller. It sits in a 4 KB peripheral window on a simple 32-bit word bus. Writes are taken on the clock edge. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low.

The bank stores:
- four panel timing words;
- the upper and lower frame base addresses;
- an interrupt mask and a sticky raw interrupt status;
- a control word.

From these it decodes, continuously:
- the panel width and height;
- the display-on condition;
- the pixel-depth code;
- the color-swap and byte/pixel-order flags.

A fixed window returns identification bytes. A 128-word window is forwarded to an external palette store through a separate port.

Two one-cycle pulses follow each access by one clock:
- `invalidate` follows any write that lands on a defined location, so downstream display logic knows its cached picture is stale;
- `access_err` follows any access to an undefined location.

Raw interrupt status bits are set from the `irq_set` input, which stands in for the real interrupt sources.

Top module: `lcd_regbank`

## Requirements
- R1: After reset every stored register is zero: `lcd_on` is 0, `panel_width` is 16, `panel_height` is 1, and `invalidate` and `access_err` are 0.
- R2: Address bits [11:2] form the word index. Words 0–3 hold timing 0–3, word 4 the upper base, word 5 the lower base, word 6 the interrupt mask (low IRQ_W bits) and word 7 the control word (low 12 bits). Each reads back what was written, zero-extended.
- R3: `panel_width` equals ((timing0 & 0xFC) + 4) × 4 and follows every write of timing word 0.
- R4: `panel_height` equals (timing1 & 0x3FF) + 1 and follows every write of timing word 1.
- R5: Control word bit 0 is enable and bit 11 is power. `lcd_on` is 1 only when both are 1. `pix_depth` is control bits [3:1]. `bgr_swap` is bit 8, `be_byte` is bit 9 and `be_pixel` is bit 10.
- R6: A 1 on `irq_set[i]` sets raw status bit i, which stays set. Word 8 reads raw status and word 9 reads raw status AND mask.
- R7: Writing word 10 clears each raw status bit whose written bit is 1. A set on the same cycle wins over the clear. Word 10 reads as zero.
- R8: Words 11 and 12 read the upper and lower base. Writes to words 8, 9, 11 and 12 change nothing.
- R9: Words at byte offsets 0xFE0–0xFFC read 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising address order, zero-extended.
- R10: Byte offsets 0x200–0x3FC are forwarded to the palette port. `pal_idx` equals address bits [8:2], `pal_we` is pulsed with `pal_wdata` equal to the bus write data, `pal_re` is raised on reads, and the bus read returns `pal_rdata`.
- R11: One cycle after a write to any defined location (registers, palette, identification window), `invalidate` is high for exactly one cycle.
- R12: Accesses to any other word (indices 13–127 and 256–1015) read as zero, store nothing and raise `access_err` for one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pal_we | output | 1 | Palette write strobe |
| pal_re | output | 1 | Palette read strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |
| irq_set | input | IRQ_W | Raw status set requests |
| lcd_on | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Pixel-depth code |
| bgr_swap | output | 1 | Red/blue swap |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order |
| panel_width | output | 11 | Decoded width in pixels |
| panel_height | output | 11 | Decoded height in lines |
| invalidate | output | 1 | Pulse after a defined write |
| access_err | output | 1 | Pulse after an undefined access |

## Verification
Width decoding is tried with three timing-0 patterns:
- all low bits set, which gives the 1024-pixel maximum;
- a mid value;
- a value with bits [1:0] set, which must not change the result.

Height decoding is tried with both the full 10-bit field and a word carrying stray upper bits. The control word is tried with enable alone, power alone, both together, and all order flags, which separates the AND of enable and power from either bit alone. Interrupt patterns tell masked from raw reads, partial clears from full clears, and a set that arrives with a clear.

// File: rtl/lcd_regbank_pkg.sv
// Package: shared constants and helpers for the LCD register bank.
// Assumes a 4 KB window decoded on 32-bit word boundaries.
package lcd_regbank_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_REG  = 2'd1,
        RGN_PAL  = 2'd2,
        RGN_ID   = 2'd3
    } region_e;

    localparam int unsigned NUM_TIMING = 4;
    localparam int unsigned CTRL_W     = 12;

    // Word indices of the register area
    localparam logic [9:0] WI_UBASE = 10'd4;
    localparam logic [9:0] WI_LBASE = 10'd5;
    localparam logic [9:0] WI_MASK  = 10'd6;
    localparam logic [9:0] WI_CTRL  = 10'd7;
    localparam logic [9:0] WI_RAW   = 10'd8;
    localparam logic [9:0] WI_MSKD  = 10'd9;
    localparam logic [9:0] WI_CLR   = 10'd10;
    localparam logic [9:0] WI_UCUR  = 10'd11;
    localparam logic [9:0] WI_LCUR  = 10'd12;
    localparam logic [9:0] WI_LAST  = 10'd12;

    // Window bounds in word indices
    localparam logic [9:0] WI_PAL_LO = 10'd128;
    localparam logic [9:0] WI_PAL_HI = 10'd255;
    localparam logic [9:0] WI_ID_LO  = 10'd1016;

    // Control bit positions
    localparam int unsigned CB_EN     = 0;
    localparam int unsigned CB_BGR    = 8;
    localparam int unsigned CB_BEBYTE = 9;
    localparam int unsigned CB_BEPIX  = 10;
    localparam int unsigned CB_PWR    = 11;

    // Identification byte for slot k of the ID window
    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcd_addr_decode.sv
// Address decoder: splits a byte address into region, word index,
// palette index and ID slot. Purely combinational; bits [1:0] ignored.
module lcd_addr_decode
    import lcd_regbank_pkg::*;
(
    input  logic [11:0] addr,
    output region_e     region,
    output logic [9:0]  word,
    output logic [6:0]  pal_idx,
    output logic [2:0]  id_sel
);

    assign word    = addr[11:2];
    assign pal_idx = addr[8:2];
    assign id_sel  = addr[4:2];

    // Classify the word index into one of the windows
    always_comb begin
        if (word <= WI_LAST)
            region = RGN_REG;
        else if (word >= WI_PAL_LO && word <= WI_PAL_HI)
            region = RGN_PAL;
        else if (word >= WI_ID_LO)
            region = RGN_ID;
        else
            region = RGN_NONE;
    end

endmodule

// File: rtl/lcd_geom.sv
// Geometry decoder: derives panel width and height from the packed
// timing words. Combinational; clk/rst_n serve only its assertions.
module lcd_geom #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GEOM_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] timing0,
    input  logic [DATA_W-1:0] timing1,
    output logic [GEOM_W-1:0] width,
    output logic [GEOM_W-1:0] height
);

    localparam int unsigned PPL_W = 6;
    localparam int unsigned LPP_W = 10;

    // Width: (pixels-per-line field + 1) * 16
    assign width  = (GEOM_W'(timing0[2 +: PPL_W]) + GEOM_W'(1)) << 4;
    // Height: lines-per-panel field + 1
    assign height = GEOM_W'(timing1[LPP_W-1:0]) + GEOM_W'(1);

    AST_WIDTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        width[3:0] == 4'd0 && width >= GEOM_W'(16) && width <= GEOM_W'(1024)); // R3
    AST_HEIGHT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        height >= GEOM_W'(1) && height <= GEOM_W'(1024)); // R4

endmodule

// File: rtl/lcd_irq_status.sv
// Interrupt status: sticky raw bits set by request, cleared by a
// write-one-to-clear; holds the mask and forms the masked view.
// Assumes a set and a clear on the same bit in one cycle leaves it set.
module lcd_irq_status #(
    parameter int unsigned IRQ_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_req,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_val,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_val,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] masked
);

    // Raw status update: clear first, then set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw <= '0;
        else
            raw <= (raw & ~(clr_we ? clr_val : '0)) | set_req;
    end

    // Mask register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_we)
            mask <= mask_val;
    end

    assign masked = raw & mask;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        |set_req |=> ((raw & $past(set_req)) == $past(set_req))); // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_req == '0) |=> ((raw & $past(clr_val)) == '0)); // R7

endmodule

// File: rtl/lcd_regbank.sv
// LCD controller register bank: timing, base, mask, control and status
// registers behind a 32-bit word bus, palette forwarding, ID bytes,
// decoded geometry and control flags, invalidate/error pulses.
// Assumes single-cycle accesses qualified by bus_sel; read data is
// combinational; bus_addr[1:0] are ignored.
module lcd_regbank
    import lcd_regbank_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IRQ_W  = 5,
    parameter int unsigned GEOM_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pal_we,
    output logic              pal_re,
    output logic [6:0]        pal_idx,
    output logic [DATA_W-1:0] pal_wdata,
    input  logic [DATA_W-1:0] pal_rdata,
    input  logic [IRQ_W-1:0]  irq_set,
    output logic              lcd_on,
    output logic [2:0]        pix_depth,
    output logic              bgr_swap,
    output logic              be_byte,
    output logic              be_pixel,
    output logic [GEOM_W-1:0] panel_width,
    output logic [GEOM_W-1:0] panel_height,
    output logic              invalidate,
    output logic              access_err
);

    region_e           region;
    logic [9:0]        word;
    logic [2:0]        id_sel;
    logic              wr_reg;
    logic [DATA_W-1:0] timing_q [NUM_TIMING];
    logic [DATA_W-1:0] ubase_q;
    logic [DATA_W-1:0] lbase_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [IRQ_W-1:0]  irq_raw;
    logic [IRQ_W-1:0]  irq_mask;
    logic [IRQ_W-1:0]  irq_masked;

    lcd_addr_decode u_dec (
        .addr    (bus_addr),
        .region  (region),
        .word    (word),
        .pal_idx (pal_idx),
        .id_sel  (id_sel)
    );

    assign wr_reg = bus_sel && bus_wr && (region == RGN_REG);

    // Timing registers, one process per word
    for (genvar g = 0; g < NUM_TIMING; g++) begin : g_timing
        always_ff @(posedge clk) begin
            if (!rst_n)
                timing_q[g] <= '0;
            else if (wr_reg && word == 10'(g))
                timing_q[g] <= bus_wdata;
        end
    end

    // Frame base and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ubase_q <= '0;
            lbase_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_reg) begin
            if (word == WI_UBASE) ubase_q <= bus_wdata;
            if (word == WI_LBASE) lbase_q <= bus_wdata;
            if (word == WI_CTRL)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
        end
    end

    lcd_irq_status #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (irq_set),
        .clr_we   (wr_reg && word == WI_CLR),
        .clr_val  (bus_wdata[IRQ_W-1:0]),
        .mask_we  (wr_reg && word == WI_MASK),
        .mask_val (bus_wdata[IRQ_W-1:0]),
        .raw      (irq_raw),
        .mask     (irq_mask),
        .masked   (irq_masked)
    );

    lcd_geom #(.DATA_W(DATA_W), .GEOM_W(GEOM_W)) u_geom (
        .clk     (clk),
        .rst_n   (rst_n),
        .timing0 (timing_q[0]),
        .timing1 (timing_q[1]),
        .width   (panel_width),
        .height  (panel_height)
    );

    // Palette forwarding
    assign pal_we    = bus_sel && bus_wr && (region == RGN_PAL);
    assign pal_re    = bus_sel && !bus_wr && (region == RGN_PAL);
    assign pal_wdata = bus_wdata;

    // Control decode
    assign lcd_on    = ctrl_q[CB_EN] && ctrl_q[CB_PWR];
    assign pix_depth = ctrl_q[3:1];
    assign bgr_swap  = ctrl_q[CB_BGR];
    assign be_byte   = ctrl_q[CB_BEBYTE];
    assign be_pixel  = ctrl_q[CB_BEPIX];

    // Read-data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (region)
                RGN_PAL: bus_rdata = pal_rdata;
                RGN_ID:  bus_rdata = DATA_W'(id_byte(id_sel));
                RGN_REG: begin
                    case (word)
                        10'd0, 10'd1, 10'd2, 10'd3:
                                  bus_rdata = timing_q[word[1:0]];
                        WI_UBASE: bus_rdata = ubase_q;
                        WI_LBASE: bus_rdata = lbase_q;
                        WI_MASK:  bus_rdata = DATA_W'(irq_mask);
                        WI_CTRL:  bus_rdata = DATA_W'(ctrl_q);
                        WI_RAW:   bus_rdata = DATA_W'(irq_raw);
                        WI_MSKD:  bus_rdata = DATA_W'(irq_masked);
                        WI_UCUR:  bus_rdata = ubase_q;
                        WI_LCUR:  bus_rdata = lbase_q;
                        default:  bus_rdata = '0;
                    endcase
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // One-cycle invalidate and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            invalidate <= 1'b0;
            access_err <= 1'b0;
        end else begin
            invalidate <= bus_sel && bus_wr && (region != RGN_NONE);
            access_err <= bus_sel && (region == RGN_NONE);
        end
    end

    AST_INVAL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && region != RGN_NONE) |=> invalidate); // R11
    AST_ERR_ON_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && region == RGN_NONE) |=> access_err); // R12
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalidate && access_err)); // R11
    AST_PAL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !(pal_we && pal_re)); // R10
    AST_ON_NEEDS_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_on) |-> $past(wr_reg && word == WI_CTRL)); // R5

endmodule

// File: tb/sim_lcd_regbank.sv
// Directed bench for lcd_regbank: one task per scenario.
module sim_lcd_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_W      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pal_we, pal_re;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata;
    logic [31:0] pal_rdata;
    logic [IRQ_W-1:0] irq_set = '0;
    logic        lcd_on, bgr_swap, be_byte, be_pixel, invalidate, access_err;
    logic [2:0]  pix_depth;
    logic [10:0] panel_width, panel_height;

    int checks = 0;
    int errors = 0;

    // Captured by the access tasks
    logic        cap_inval, cap_err, cap_pwe, cap_pre;
    logic [6:0]  cap_pidx;
    logic [31:0] cap_pwdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pal_rdata = 32'hCAFE_0000 | {25'd0, pal_idx};

    lcd_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pal_we(pal_we), .pal_re(pal_re), .pal_idx(pal_idx),
        .pal_wdata(pal_wdata), .pal_rdata(pal_rdata), .irq_set(irq_set),
        .lcd_on(lcd_on), .pix_depth(pix_depth), .bgr_swap(bgr_swap),
        .be_byte(be_byte), .be_pixel(be_pixel), .panel_width(panel_width),
        .panel_height(panel_height), .invalidate(invalidate),
        .access_err(access_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        cap_pwe = pal_we; cap_pidx = pal_idx; cap_pwdata = pal_wdata;
        @(posedge clk); #1;
        cap_inval = invalidate; cap_err = access_err;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata; cap_pre = pal_re; cap_pidx = pal_idx;
        @(posedge clk); #1;
        cap_inval = invalidate; cap_err = access_err;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 lcd_on", {31'd0, lcd_on}, 32'd0);
        check("R1 width", {21'd0, panel_width}, 32'd16);
        check("R1 height", {21'd0, panel_height}, 32'd1);
        check("R1 pulses", {30'd0, invalidate, access_err}, 32'd0);
        for (int i = 0; i < 13; i++) begin
            do_read(12'(i*4), v);
            check("R1 reg zero", v, 32'd0);
        end
    endtask

    task automatic t_readback();
        logic [31:0] v;
        do_write(12'h008, 32'hDEAD_BEEF);
        check("R11 inval after write", {31'd0, cap_inval}, 32'd1);
        do_read(12'h008, v);  check("R2 timing2", v, 32'hDEAD_BEEF);
        check("R11 no inval on read", {31'd0, cap_inval}, 32'd0);
        do_write(12'h00C, 32'h1234_5678);
        do_read(12'h00C, v);  check("R2 timing3", v, 32'h1234_5678);
        do_write(12'h010, 32'h8000_1000);
        do_write(12'h014, 32'h8004_0000);
        do_read(12'h010, v);  check("R2 upper base", v, 32'h8000_1000);
        do_read(12'h014, v);  check("R2 lower base", v, 32'h8004_0000);
        do_read(12'h02C, v);  check("R8 upper current", v, 32'h8000_1000);
        do_read(12'h030, v);  check("R8 lower current", v, 32'h8004_0000);
        do_write(12'h02C, 32'h0);
        check("R11 inval read-only write", {31'd0, cap_inval}, 32'd1);
        do_read(12'h010, v);  check("R8 write to current ignored", v, 32'h8000_1000);
        do_write(12'h018, 32'hFFFF_FFFF);
        do_read(12'h018, v);  check("R2 mask width", v, 32'h0000_001F);
        do_write(12'h018, 32'h0);
        do_write(12'h01C, 32'hFFFF_F000);
        do_read(12'h01C, v);  check("R2 control width", v, 32'h0);
    endtask

    task automatic t_geometry();
        do_write(12'h000, 32'h0000_00FF);
        check("R3 width max", {21'd0, panel_width}, 32'd1024);
        do_write(12'h000, 32'h0000_003C);
        check("R3 width mid", {21'd0, panel_width}, 32'd256);
        do_write(12'h000, 32'hFFFF_FF13);
        check("R3 width low bits ignored", {21'd0, panel_width}, 32'd80);
        do_write(12'h004, 32'h0000_03FF);
        check("R4 height max", {21'd0, panel_height}, 32'd1024);
        do_write(12'h004, 32'hFFFF_F0EF);
        check("R4 height masked", {21'd0, panel_height}, 32'd240);
    endtask

    task automatic t_control();
        do_write(12'h01C, 32'h0000_0001);
        check("R5 enable only", {31'd0, lcd_on}, 32'd0);
        do_write(12'h01C, 32'h0000_0800);
        check("R5 power only", {31'd0, lcd_on}, 32'd0);
        do_write(12'h01C, 32'h0000_0801);
        check("R5 both", {31'd0, lcd_on}, 32'd1);
        do_write(12'h01C, 32'h0000_0F0F);
        check("R5 flags", {26'd0, lcd_on, pix_depth, bgr_swap, be_byte, be_pixel},
              {26'd0, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1});
        do_write(12'h01C, 32'h0000_0204);
        check("R5 depth2 byte only", {26'd0, lcd_on, pix_depth, bgr_swap, be_byte, be_pixel},
              {26'd0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0});
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); irq_set = 5'b10110;
        @(posedge clk); #1; irq_set = '0;
        do_write(12'h018, 32'h0000_0007);
        do_read(12'h020, v); check("R6 raw", v, 32'h16);
        do_read(12'h024, v); check("R6 masked", v, 32'h06);
        do_write(12'h020, 32'h0);
        do_read(12'h020, v); check("R6 raw read-only", v, 32'h16);
        do_write(12'h028, 32'h0000_0012);
        do_read(12'h020, v); check("R7 partial clear", v, 32'h04);
        do_read(12'h028, v); check("R7 clear reads zero", v, 32'h0);
        irq_set = 5'b00001;
        do_write(12'h028, 32'h0000_001F);
        irq_set = '0;
        do_read(12'h020, v); check("R7 set wins", v, 32'h01);
        do_write(12'h028, 32'h0000_001F);
        do_read(12'h020, v); check("R7 full clear", v, 32'h0);
    endtask

    task automatic t_id();
        logic [31:0] v;
        logic [7:0] exp_id [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            do_read(12'hFE0 + 12'(i*4), v);
            check("R9 id byte", v, {24'd0, exp_id[i]});
            check("R12 id no err", {31'd0, cap_err}, 32'd0);
        end
    endtask

    task automatic t_palette();
        logic [31:0] v;
        do_write(12'h3FC, 32'h0000_7FFF);
        check("R10 pal_we", {31'd0, cap_pwe}, 32'd1);
        check("R10 pal idx write", {25'd0, cap_pidx}, 32'd127);
        check("R10 pal wdata", cap_pwdata, 32'h0000_7FFF);
        check("R11 inval palette", {31'd0, cap_inval}, 32'd1);
        do_read(12'h208, v);
        check("R10 pal_re", {31'd0, cap_pre}, 32'd1);
        check("R10 pal idx read", {25'd0, cap_pidx}, 32'd2);
        check("R10 pal rdata", v, 32'hCAFE_0002);
        do_write(12'h010, 32'h1);
        check("R10 no pal_we off window", {31'd0, cap_pwe}, 32'd0);
    endtask

    task automatic t_undefined();
        logic [31:0] v;
        do_read(12'h034, v);
        check("R12 undef read zero", v, 32'd0);
        check("R12 err pulse", {31'd0, cap_err}, 32'd1);
        @(posedge clk); #1;
        check("R12 err one cycle", {31'd0, access_err}, 32'd0);
        do_write(12'h400, 32'hFFFF_FFFF);
        check("R12 err on write", {31'd0, cap_err}, 32'd1);
        check("R11 no inval undef", {31'd0, cap_inval}, 32'd0);
        do_read(12'hFDC, v);
        check("R12 below id window", {cap_err, v[30:0]}, 32'h8000_0000);
        do_read(12'h010, v);
        check("R12 undefined write stored nothing", v, 32'h1);
        check("R12 no err on defined", {31'd0, cap_err}, 32'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_readback();
        t_geometry();
        t_control();
        t_irq();
        t_id();
        t_palette();
        t_undefined();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule